// File: doc/BRIEF.md
# DDR4 Power-Up Initialization Sequencer

This block takes a DDR4 SDRAM from the moment power is stable to an idle, usable state without any help from software. After a start pulse it first releases the memory reset with termination enabled and the clock enable low. After a long wait it raises the clock enable and waits again. It then writes the seven mode registers in the order the memory requires and issues a long ZQ calibration. After a last wait it raises a done flag, which stays high until reset.

Commands are driven on a four-phase command bus. Every command of the sequence goes out on phase 0, and phases 1 to 3 carry no-operation throughout. In normal operation reads use phase 1 and writes use phase 3, so the controller that takes over after `init_done` finds those phases untouched. Each delay is a parameter counted in controller clocks. A simulation can therefore shrink the 50000 / 10000 / 200 / 200 cycle defaults.

Top module: `ddr4_init_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `mem_rst_n`, `mem_cke`, `mem_odt`, `cmd_valid`, `init_done`, all phase command bits, `cmd_bank` and `cmd_addr` are 0.
- R2: A start pulse seen in idle at clock edge t0 makes `mem_rst_n` and `mem_odt` 1 and `mem_cke` 0 from edge t0. Bank and address stay 0. Both lines then stay 1 until reset.
- R3: `mem_cke` rises at edge t0+T_RST+1 and stays 1 until reset.
- R4: Mode-register-set commands (phase-0 cs, ras, cas and we all 1) go out on seven consecutive edges, the first at t0+T_RST+T_CKE+2. The banks are 3, 6, 5, 4, 2, 1, 0 in that order.
- R5: The mode-register address is 0x000 for banks 3, 6, 5 and 4, 0x200 for bank 2, 0x301 for bank 1 and 0x110 for bank 0.
- R6: The ZQ calibration command (phase-0 cs and we 1, ras and cas 0, address 0x400, bank 0) goes out T_MRD+1 edges after the bank-0 mode-register command.
- R7: `init_done` rises T_ZQ+1 edges after the ZQ command and then stays 1, with no further command, until reset.
- R8: `cmd_valid` is 1 for exactly one clock per command (eight in a sequence). When it is 0, all phase-0 command bits, `cmd_bank` and `cmd_addr` are 0.
- R9: Phases 1 to 3 (bits 3:1 of each phase bus) stay 0 at all times.
- R10: A start pulse while the sequence runs or after `init_done` has no effect on any output.
- R11: A reset in the middle of the sequence returns every output to its R1 value. A following start runs the complete sequence again from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts the sequence when idle |
| mem_rst_n | output | 1 | Memory reset line, active low |
| mem_cke | output | 1 | Memory clock enable |
| mem_odt | output | 1 | On-die termination enable |
| ph_cs | output | NPH | Chip-select asserted, one bit per phase |
| ph_ras | output | NPH | Row strobe asserted, one bit per phase |
| ph_cas | output | NPH | Column strobe asserted, one bit per phase |
| ph_we | output | NPH | Write enable asserted, one bit per phase |
| cmd_bank | output | BANK_W | Bank address of the phase-0 command |
| cmd_addr | output | ADDR_W | Address of the phase-0 command |
| cmd_valid | output | 1 | Marks the clock that carries a command |
| init_done | output | 1 | Sequence complete, held until reset |

## Verification
The bench targets the exact edge of every transition. A timer that is off by one shifts clock enable, the first mode-register write, the ZQ command or done by one cycle, and the per-clock comparison reports it. It checks the mode-register bank order and per-bank addresses, which a swapped table entry would corrupt, and it checks that ZQ drops ras and cas. Start pulses during the run and after completion, plus a start held for several cycles, would restart or stretch a design that re-arms on start. A reset in the middle of the mode-register writes catches control lines or a step index that survive reset.

// File: rtl/ddr4_init_pkg.sv
package ddr4_init_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        STEP_POWER,
        STEP_CLKEN,
        STEP_MRS,
        STEP_ZQCL
    } step_kind_e;

    typedef struct packed {
        logic cs;
        logic ras;
        logic cas;
        logic we;
    } mem_cmd_t;

    localparam mem_cmd_t CMD_NOP  = '{cs: 1'b0, ras: 1'b0, cas: 1'b0, we: 1'b0};
    localparam mem_cmd_t CMD_MRS  = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b1};
    localparam mem_cmd_t CMD_ZQCL = '{cs: 1'b1, ras: 1'b0, cas: 1'b0, we: 1'b1};

    // Step numbering: 0 power, 1 clock enable, 2..8 mode registers, 9 ZQ
    localparam int unsigned STEP_W      = 4;
    localparam int unsigned N_MRS       = 7;
    localparam int unsigned STEP_MRS_LO = 2;
    localparam int unsigned STEP_MRS_HI = STEP_MRS_LO + N_MRS - 1;
    localparam int unsigned STEP_LAST   = STEP_MRS_HI + 1;

    // Mode-register write order required by the memory
    function automatic logic [2:0] mrs_bank(input logic [STEP_W-1:0] k);
        logic [2:0] b;
        case (k)
            4'd0:    b = 3'd3;
            4'd1:    b = 3'd6;
            4'd2:    b = 3'd5;
            4'd3:    b = 3'd4;
            4'd4:    b = 3'd2;
            4'd5:    b = 3'd1;
            default: b = 3'd0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ddr4_init_step_rom.sv
module ddr4_init_step_rom
    import ddr4_init_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BANK_W = 3,
    parameter int WAIT_W = 16,
    parameter int T_RST  = 50000,
    parameter int T_CKE  = 10000,
    parameter int T_MRD  = 200,
    parameter int T_ZQ   = 200
) (
    input  logic [STEP_W-1:0] step_idx,
    output step_kind_e        kind,
    output mem_cmd_t          cmd,
    output logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr,
    output logic [WAIT_W-1:0] wait_cyc
);

    logic [STEP_W-1:0] mrs_k;
    logic [2:0]        mrs_b;

    assign mrs_k = step_idx - STEP_W'(STEP_MRS_LO);
    assign mrs_b = mrs_bank(mrs_k);

    always_comb begin
        kind     = STEP_POWER;
        cmd      = CMD_NOP;
        bank     = '0;
        addr     = '0;
        wait_cyc = '0;
        if (step_idx == '0) begin
            kind     = STEP_POWER;
            wait_cyc = WAIT_W'(T_RST);
        end else if (step_idx == STEP_W'(1)) begin
            kind     = STEP_CLKEN;
            wait_cyc = WAIT_W'(T_CKE);
        end else if (step_idx <= STEP_W'(STEP_MRS_HI)) begin
            kind = STEP_MRS;
            cmd  = CMD_MRS;
            bank = BANK_W'(mrs_b);
            case (mrs_b)
                3'd2:    addr = ADDR_W'(12'h200);
                3'd1:    addr = ADDR_W'(12'h301);
                3'd0:    addr = ADDR_W'(12'h110);
                default: addr = '0;
            endcase
            if (step_idx == STEP_W'(STEP_MRS_HI)) begin
                wait_cyc = WAIT_W'(T_MRD);
            end
        end else begin
            kind     = STEP_ZQCL;
            cmd      = CMD_ZQCL;
            addr     = ADDR_W'(12'h400);
            wait_cyc = WAIT_W'(T_ZQ);
        end
    end

endmodule

// File: rtl/ddr4_init_wait_timer.sv
module ddr4_init_wait_timer #(
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              expired
);

    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr4_init_phase_drive.sv
module ddr4_init_phase_drive
    import ddr4_init_pkg::*;
#(
    parameter int NPH    = 4,
    parameter int ADDR_W = 17,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  mem_cmd_t          cmd_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              set_power,
    input  logic              set_clken,
    input  logic              set_done,
    output logic              mem_rst_n,
    output logic              mem_cke,
    output logic              mem_odt,
    output logic [NPH-1:0]    ph_cs,
    output logic [NPH-1:0]    ph_ras,
    output logic [NPH-1:0]    ph_cas,
    output logic [NPH-1:0]    ph_we,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_valid,
    output logic              init_done
);

    typedef struct packed {
        logic              rst_n;
        logic              cke;
        logic              odt;
        logic              done;
        logic              valid;
        mem_cmd_t          cmd;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
    } drv_t;

    drv_t drv_d, drv_q;

    always_comb begin
        drv_d       = drv_q;
        drv_d.valid = issue;
        drv_d.cmd   = issue ? cmd_in  : CMD_NOP;
        drv_d.bank  = issue ? bank_in : '0;
        drv_d.addr  = issue ? addr_in : '0;
        if (set_power) begin
            drv_d.rst_n = 1'b1;
            drv_d.odt   = 1'b1;
        end
        if (set_clken) begin
            drv_d.cke = 1'b1;
        end
        if (set_done) begin
            drv_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign mem_rst_n = drv_q.rst_n;
    assign mem_cke   = drv_q.cke;
    assign mem_odt   = drv_q.odt;
    assign cmd_bank  = drv_q.bank;
    assign cmd_addr  = drv_q.addr;
    assign cmd_valid = drv_q.valid;
    assign init_done = drv_q.done;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        if (p == 0) begin : g_live
            assign ph_cs[p]  = drv_q.cmd.cs;
            assign ph_ras[p] = drv_q.cmd.ras;
            assign ph_cas[p] = drv_q.cmd.cas;
            assign ph_we[p]  = drv_q.cmd.we;
        end else begin : g_nop
            assign ph_cs[p]  = 1'b0;
            assign ph_ras[p] = 1'b0;
            assign ph_cas[p] = 1'b0;
            assign ph_we[p]  = 1'b0;
        end
    end

endmodule

// File: rtl/ddr4_init_seq.sv
module ddr4_init_seq
    import ddr4_init_pkg::*;
#(
    parameter int NPH    = 4,
    parameter int ADDR_W = 17,
    parameter int BANK_W = 3,
    parameter int T_RST  = 50000,
    parameter int T_CKE  = 10000,
    parameter int T_MRD  = 200,
    parameter int T_ZQ   = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              mem_rst_n,
    output logic              mem_cke,
    output logic              mem_odt,
    output logic [NPH-1:0]    ph_cs,
    output logic [NPH-1:0]    ph_ras,
    output logic [NPH-1:0]    ph_cas,
    output logic [NPH-1:0]    ph_we,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_valid,
    output logic              init_done
);

    localparam int MAX_A    = (T_RST > T_CKE) ? T_RST : T_CKE;
    localparam int MAX_B    = (T_MRD > T_ZQ)  ? T_MRD : T_ZQ;
    localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int WAIT_W   = $clog2(MAX_WAIT + 1) < 1 ? 1 : $clog2(MAX_WAIT + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              fire;
    logic              set_done;
    logic [STEP_W-1:0] idx;
    logic              expired;
    step_kind_e        kind;
    mem_cmd_t          rom_cmd;
    logic [BANK_W-1:0] rom_bank;
    logic [ADDR_W-1:0] rom_addr;
    logic [WAIT_W-1:0] rom_wait;

    always_comb begin
        seq_d    = seq_q;
        fire     = 1'b0;
        set_done = 1'b0;
        idx      = '0;
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (start) begin
                    fire       = 1'b1;
                    seq_d.st   = SQ_RUN;
                    seq_d.step = '0;
                end
            end
            SQ_RUN: begin
                if (expired) begin
                    if (seq_q.step == STEP_W'(STEP_LAST)) begin
                        seq_d.st = SQ_DONE;
                        set_done = 1'b1;
                    end else begin
                        fire       = 1'b1;
                        idx        = seq_q.step + 1'b1;
                        seq_d.step = idx;
                    end
                end
            end
            default: begin
                seq_d = seq_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: SQ_IDLE, step: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    ddr4_init_step_rom #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .WAIT_W (WAIT_W),
        .T_RST  (T_RST),
        .T_CKE  (T_CKE),
        .T_MRD  (T_MRD),
        .T_ZQ   (T_ZQ)
    ) u_rom (
        .step_idx (idx),
        .kind     (kind),
        .cmd      (rom_cmd),
        .bank     (rom_bank),
        .addr     (rom_addr),
        .wait_cyc (rom_wait)
    );

    ddr4_init_wait_timer #(
        .WAIT_W (WAIT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (fire),
        .load_val (rom_wait),
        .expired  (expired)
    );

    ddr4_init_phase_drive #(
        .NPH    (NPH),
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_drive (
        .clk       (clk),
        .rst       (rst),
        .issue     (fire && (kind == STEP_MRS || kind == STEP_ZQCL)),
        .cmd_in    (rom_cmd),
        .bank_in   (rom_bank),
        .addr_in   (rom_addr),
        .set_power (fire && kind == STEP_POWER),
        .set_clken (fire && kind == STEP_CLKEN),
        .set_done  (set_done),
        .mem_rst_n (mem_rst_n),
        .mem_cke   (mem_cke),
        .mem_odt   (mem_odt),
        .ph_cs     (ph_cs),
        .ph_ras    (ph_ras),
        .ph_cas    (ph_cas),
        .ph_we     (ph_we),
        .cmd_bank  (cmd_bank),
        .cmd_addr  (cmd_addr),
        .cmd_valid (cmd_valid),
        .init_done (init_done)
    );

endmodule

// File: rtl/ddr4_init_chk.sv
module ddr4_init_chk #(
    parameter int NPH    = 4,
    parameter int ADDR_W = 17,
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rst_n,
    input logic              mem_cke,
    input logic              mem_odt,
    input logic [NPH-1:0]    ph_cs,
    input logic [NPH-1:0]    ph_ras,
    input logic [NPH-1:0]    ph_cas,
    input logic [NPH-1:0]    ph_we,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_valid,
    input logic              init_done
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_rst_n && !mem_cke && !mem_odt && !cmd_valid && !init_done));

    p_lines_hold_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rst_n |=> (mem_rst_n && mem_odt));

    p_cke_after_reset_r3: assert property (@(posedge clk) disable iff (rst)
        mem_cke |-> mem_rst_n);

    p_mrs_full_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ph_ras[0]) |-> (ph_cas[0] && ph_we[0] && ph_cs[0] && mem_cke));

    p_zq_fields_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !ph_ras[0]) |-> (!ph_cas[0] && ph_we[0] && cmd_bank == '0
                                       && cmd_addr == ADDR_W'(12'h400)));

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && !cmd_valid));

    p_valid_has_cs_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ph_cs[0]);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (ph_cs == '0 && ph_ras == '0 && ph_cas == '0 && ph_we == '0
                        && cmd_bank == '0 && cmd_addr == '0));

    p_upper_nop_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({ph_cs[NPH-1:1], ph_ras[NPH-1:1], ph_cas[NPH-1:1], ph_we[NPH-1:1]}) == 0);

endmodule

bind ddr4_init_seq ddr4_init_chk #(
    .NPH    (NPH),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rst_n (mem_rst_n),
    .mem_cke   (mem_cke),
    .mem_odt   (mem_odt),
    .ph_cs     (ph_cs),
    .ph_ras    (ph_ras),
    .ph_cas    (ph_cas),
    .ph_we     (ph_we),
    .cmd_bank  (cmd_bank),
    .cmd_addr  (cmd_addr),
    .cmd_valid (cmd_valid),
    .init_done (init_done)
);

// File: tb/ddr4_init_seq_tb.sv
module ddr4_init_seq_tb;

    localparam int NPH    = 4;
    localparam int ADDR_W = 17;
    localparam int BANK_W = 3;
    localparam int T_RST  = 20;
    localparam int T_CKE  = 9;
    localparam int T_MRD  = 4;
    localparam int T_ZQ   = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              mem_rst_n, mem_cke, mem_odt;
    logic [NPH-1:0]    ph_cs, ph_ras, ph_cas, ph_we;
    logic [BANK_W-1:0] cmd_bank;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_valid, init_done;

    always #10 clk = ~clk;

    ddr4_init_seq #(
        .NPH (NPH), .ADDR_W (ADDR_W), .BANK_W (BANK_W),
        .T_RST (T_RST), .T_CKE (T_CKE), .T_MRD (T_MRD), .T_ZQ (T_ZQ)
    ) u_dut (
        .clk (clk), .rst (rst), .start (start),
        .mem_rst_n (mem_rst_n), .mem_cke (mem_cke), .mem_odt (mem_odt),
        .ph_cs (ph_cs), .ph_ras (ph_ras), .ph_cas (ph_cas), .ph_we (ph_we),
        .cmd_bank (cmd_bank), .cmd_addr (cmd_addr),
        .cmd_valid (cmd_valid), .init_done (init_done)
    );

    typedef struct {
        bit       rst_n, cke, odt, valid, cs, ras, cas, we, done;
        int       bank;
        int       addr;
    } exp_t;

    int   checks = 0;
    int   errors = 0;
    exp_t cur;
    exp_t q[$];
    int   mdl_state = 0;   // 0 idle, 1 running, 2 finished
    bit   cmp_en = 1'b0;
    int   valid_seen = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic exp_t zero_rec();
        exp_t r;
        r = '{default: 0};
        return r;
    endfunction

    // Builds the expected outputs for every edge t = 0 .. done edge after an accepted start
    task automatic build_sequence();
        int bank_ord[7] = '{3, 6, 5, 4, 2, 1, 0};
        int tc = T_RST + T_CKE + 2;
        int tz = tc + 6 + T_MRD + 1;
        int td = tz + T_ZQ + 1;
        q.delete();
        for (int t = 0; t <= td; t++) begin
            exp_t r = zero_rec();
            r.rst_n = 1; r.odt = 1;
            r.cke   = (t >= T_RST + 1);
            if (t >= tc && t <= tc + 6) begin
                r.valid = 1; r.cs = 1; r.ras = 1; r.cas = 1; r.we = 1;
                r.bank  = bank_ord[t - tc];
                case (r.bank)
                    2: r.addr = 'h200;
                    1: r.addr = 'h301;
                    0: r.addr = 'h110;
                    default: r.addr = 0;
                endcase
            end
            if (t == tz) begin
                r.valid = 1; r.cs = 1; r.we = 1; r.addr = 'h400; r.bank = 0;
            end
            r.done = (t == td);
            q.push_back(r);
        end
    endtask

    // Behavioural reference model, advanced once per rising edge
    always @(posedge clk) begin
        cmp_en <= 1'b1;
        if (rst) begin
            cur = zero_rec();
            q.delete();
            mdl_state = 0;
        end else if (mdl_state == 0) begin
            if (start) begin
                build_sequence();
                cur = q.pop_front();
                mdl_state = 1;
            end
        end else if (mdl_state == 1) begin
            cur = q.pop_front();
            if (q.size() == 0) mdl_state = 2;
        end
    end

    // Compare every output away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2", "mem_rst_n", int'(mem_rst_n), int'(cur.rst_n));
            chk("R2", "mem_odt",   int'(mem_odt),   int'(cur.odt));
            chk("R3", "mem_cke",   int'(mem_cke),   int'(cur.cke));
            chk("R8", "cmd_valid", int'(cmd_valid), int'(cur.valid));
            chk("R4", "ph_cs0",    int'(ph_cs[0]),  int'(cur.cs));
            chk("R6", "ph_ras0",   int'(ph_ras[0]), int'(cur.ras));
            chk("R6", "ph_cas0",   int'(ph_cas[0]), int'(cur.cas));
            chk("R4", "ph_we0",    int'(ph_we[0]),  int'(cur.we));
            chk("R4", "cmd_bank",  int'(cmd_bank),  cur.bank);
            chk("R5", "cmd_addr",  int'(cmd_addr),  cur.addr);
            chk("R7", "init_done", int'(init_done), int'(cur.done));
            chk("R9", "upper phases",
                int'({ph_cs[NPH-1:1], ph_ras[NPH-1:1], ph_cas[NPH-1:1], ph_we[NPH-1:1]}), 0);
            if (cmd_valid) valid_seen++;
        end
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_cleared(input string req);
        chk(req, "reset lines", int'({mem_rst_n, mem_cke, mem_odt}), 0);
        chk(req, "cmd/done", int'({cmd_valid, init_done}), 0);
        chk(req, "bank/addr", int'(cmd_bank) + int'(cmd_addr), 0);
    endtask

    task automatic wait_done();
        while (!init_done) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_neg(3);
        check_cleared("R1");
        rst = 1'b0;
        wait_neg(1);
        check_cleared("R1");
        wait_neg(5);

        // first run, with start pulses while busy (R10)
        start = 1'b1; wait_neg(1); start = 1'b0;
        valid_seen = 0;
        wait_neg(12);
        start = 1'b1; wait_neg(1); start = 1'b0;
        wait_neg(T_RST + T_CKE - 8);
        start = 1'b1; wait_neg(1); start = 1'b0;
        wait_done();
        wait_neg(1);
        chk("R8", "commands per sequence", valid_seen, 8);

        // start after done must not restart anything (R10)
        valid_seen = 0;
        start = 1'b1; wait_neg(1); start = 1'b0;
        wait_neg(15);
        chk("R10", "commands after done", valid_seen, 0);
        chk("R7", "done held", int'(init_done), 1);

        // reset in the middle of the mode-register writes (R11)
        rst = 1'b1; wait_neg(2); rst = 1'b0;
        start = 1'b1; wait_neg(1); start = 1'b0;
        wait_neg(T_RST + T_CKE + 3);
        rst = 1'b1; wait_neg(1);
        check_cleared("R11");
        rst = 1'b0; wait_neg(1);
        check_cleared("R11");
        wait_neg(4);

        // start held high for several cycles: one sequence only
        valid_seen = 0;
        start = 1'b1; wait_neg(4); start = 1'b0;
        wait_done();
        wait_neg(10);
        chk("R11", "commands after restart", valid_seen, 8);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule